// File: doc/BRIEF.md
# Context-Pointer Register Bank

This block turns a general-purpose register number into a location in a shared on-chip data RAM. The processor names one of sixteen word registers. The block adds twice that number to a movable base held in a context pointer, then reads or writes the word at the resulting byte address. The register file therefore has no flip-flop storage of its own. A context switch is one write of a new pointer value, and no data moves. Two banks whose bases lie closer together than sixteen words share their overlapping words. A caller can place arguments in its upper registers and the callee can find them in its lower registers.

The RAM is a single-port array. It serves two requesters: the register port, and a direct byte-addressed port that reaches the same words as ordinary data. A small sequencer grants the RAM to one requester at a time, with the register port first. Each access completes in a one-cycle acknowledge state. An address that falls outside the RAM window raises an error flag in place of the access.

The sequencer states are S_IDLE, S_REG_WACK, S_REG_RACK, S_REG_FAULT, S_DIR_WACK, S_DIR_RACK and S_DIR_FAULT. From S_IDLE, a register request goes to S_REG_FAULT when its address is out of the window. Otherwise it goes to S_REG_WACK for a write or to S_REG_RACK for a read. When no register request is present, a direct request takes the matching S_DIR_* transition. With no request, the sequencer stays in S_IDLE. Every acknowledge and fault state returns to S_IDLE after one cycle.

Top module: `reg_bank_ctx`

## Requirements
- R1: During and right after reset, cp_value equals the reset base 0x100 and every done and error output is 0.
- R2: A register access to number r reaches the RAM byte address cp_value + 2*r. The word at that address is the word the direct port reaches at the same byte address.
- R3: A pointer write stores cp_wdata with bit 0 forced to 0, and cp_value shows the stored value from the next cycle on.
- R4: A pointer write changes neither RAM contents nor cp_value without cp_we. A register access that is accepted in the same cycle as a pointer write still uses the old pointer.
- R5: When two banks overlap, a write to register k of the bank at base B is read back as register k - (C-B)/2 of the bank at base C.
- R6: A register access whose byte address lies outside the window [0x100, 0x200) raises reg_err together with reg_done and returns read data 0. A write in this case leaves all RAM words unchanged.
- R7: Data written through either port is read back unchanged through either port.
- R8: reg_done or dir_done is a single-cycle pulse. It appears in the cycle after the request is accepted. Read data is valid while done is high and 0 otherwise.
- R9: When both ports request in the same cycle, the register access is served first. The direct access completes two cycles after the register access.
- R10: A direct access outside the window raises dir_err with dir_done, returns 0 and writes nothing. Bit 0 of dir_addr is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cp_we | input | 1 | Load the context pointer |
| cp_wdata | input | ADDR_W | New context pointer (bit 0 ignored) |
| cp_value | output | ADDR_W | Current context pointer |
| reg_req | input | 1 | Register access request, held until reg_done |
| reg_we | input | 1 | 1 = register write, 0 = read |
| reg_num | input | log2(NUM_REGS) | Register number |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data |
| reg_done | output | 1 | Register access complete |
| reg_err | output | 1 | Register address outside the window |
| dir_req | input | 1 | Direct access request, held until dir_done |
| dir_we | input | 1 | 1 = direct write, 0 = read |
| dir_addr | input | ADDR_W | Direct byte address |
| dir_wdata | input | DATA_W | Direct write data |
| dir_rdata | output | DATA_W | Direct read data |
| dir_done | output | 1 | Direct access complete |
| dir_err | output | 1 | Direct address outside the window |

## Verification
The bench tries several context-pointer values and, for each one, reads and writes every register number:
- An aligned base at the bottom of the window shows that the address is built from the register number.
- An odd pointer shows the alignment of bit 0.
- A base eight words higher shows aliasing between overlapping banks.
- Bases that straddle the top and bottom edges of the window separate register numbers that fault from those that do not.
- A base wholly below the window shows that every access in that bank faults.

After each pointer setting, the whole RAM is read through the direct port and compared with a model kept in the bench. This shows that faulting writes leave no trace and that the two ports agree. Simultaneous requests and a pointer write made in the cycle of an access show the priority and when a new pointer takes effect.

// File: rtl/rbank_pkg.sv
package rbank_pkg;

    typedef enum logic [2:0] {
        S_IDLE      = 3'd0,
        S_REG_WACK  = 3'd1,
        S_REG_RACK  = 3'd2,
        S_REG_FAULT = 3'd3,
        S_DIR_WACK  = 3'd4,
        S_DIR_RACK  = 3'd5,
        S_DIR_FAULT = 3'd6
    } seq_state_t;

endpackage

// File: rtl/rbank_addr_calc.sv
module rbank_addr_calc #(
    parameter int ADDR_W    = 12,
    parameter int OFFS_W    = 4,
    parameter int WIN_BASE  = 256,
    parameter int WIN_WORDS = 128,
    localparam int SUM_W    = ADDR_W + 1,
    localparam int IDX_W    = $clog2(WIN_WORDS)
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [OFFS_W-1:0] word_offs,
    output logic [IDX_W-1:0]  word_idx,
    output logic              out_of_win
);

    localparam logic [SUM_W-1:0] WIN_LO = SUM_W'(WIN_BASE);
    localparam logic [SUM_W-1:0] WIN_HI = SUM_W'(WIN_BASE + 2 * WIN_WORDS);

    logic [SUM_W-1:0] byte_addr;
    logic [SUM_W-1:0] rel_addr;

    always_comb begin
        byte_addr  = SUM_W'(base & ~ADDR_W'(1)) + (SUM_W'(word_offs) << 1);
        out_of_win = (byte_addr < WIN_LO) || (byte_addr >= WIN_HI);
        rel_addr   = byte_addr - WIN_LO;
        word_idx   = IDX_W'(rel_addr >> 1);
    end

endmodule

// File: rtl/rbank_ctx_ptr.sv
module rbank_ctx_ptr #(
    parameter int ADDR_W   = 12,
    parameter int CP_RESET = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    output logic [ADDR_W-1:0] ptr
);

    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= ADDR_W'(CP_RESET) & ALIGN_MASK;
        end else if (load) begin
            ptr <= load_val & ALIGN_MASK;
        end
    end

endmodule

// File: rtl/rbank_sram.sv
module rbank_sram #(
    parameter int DATA_W = 16,
    parameter int WORDS  = 128,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                mem[idx] <= wdata;
            end else begin
                rdata <= mem[idx];
            end
        end
    end

endmodule

// File: rtl/rbank_seq.sv
module rbank_seq
    import rbank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic reg_req,
    input  logic reg_we,
    input  logic reg_oor,
    input  logic dir_req,
    input  logic dir_we,
    input  logic dir_oor,
    output logic mem_en,
    output logic mem_we,
    output logic sel_dir,
    output logic reg_done,
    output logic reg_err,
    output logic reg_rvalid,
    output logic dir_done,
    output logic dir_err,
    output logic dir_rvalid
);

    seq_state_t state_q;
    seq_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = S_IDLE;
        unique case (state_q)
            S_IDLE: begin
                if (reg_req) begin
                    state_d = reg_oor ? S_REG_FAULT : (reg_we ? S_REG_WACK : S_REG_RACK);
                end else if (dir_req) begin
                    state_d = dir_oor ? S_DIR_FAULT : (dir_we ? S_DIR_WACK : S_DIR_RACK);
                end else begin
                    state_d = S_IDLE;
                end
            end
            S_REG_WACK, S_REG_RACK, S_REG_FAULT,
            S_DIR_WACK, S_DIR_RACK, S_DIR_FAULT: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_comb begin
        mem_en     = 1'b0;
        mem_we     = 1'b0;
        sel_dir    = 1'b0;
        reg_done   = 1'b0;
        reg_err    = 1'b0;
        reg_rvalid = 1'b0;
        dir_done   = 1'b0;
        dir_err    = 1'b0;
        dir_rvalid = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (reg_req) begin
                    mem_en = !reg_oor;
                    mem_we = reg_we && !reg_oor;
                end else if (dir_req) begin
                    sel_dir = 1'b1;
                    mem_en  = !dir_oor;
                    mem_we  = dir_we && !dir_oor;
                end
            end
            S_REG_WACK:  reg_done = 1'b1;
            S_REG_RACK: begin
                reg_done   = 1'b1;
                reg_rvalid = 1'b1;
            end
            S_REG_FAULT: begin
                reg_done = 1'b1;
                reg_err  = 1'b1;
            end
            S_DIR_WACK:  dir_done = 1'b1;
            S_DIR_RACK: begin
                dir_done   = 1'b1;
                dir_rvalid = 1'b1;
            end
            S_DIR_FAULT: begin
                dir_done = 1'b1;
                dir_err  = 1'b1;
            end
            default: ;
        endcase
    end

    // R9: a simultaneous direct request never wins the first grant
    a_r9_reg_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && reg_req && dir_req) |=> !dir_done);

    // R8: each completion is a single-cycle pulse
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        reg_done |=> !reg_done);

    a_r8_dir_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        dir_done |=> !dir_done);

endmodule

// File: rtl/reg_bank_ctx.sv
module reg_bank_ctx #(
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 12,
    parameter int NUM_REGS  = 16,
    parameter int WIN_BASE  = 256,
    parameter int WIN_WORDS = 128,
    parameter int CP_RESET  = 256,
    localparam int REG_W    = $clog2(NUM_REGS),
    localparam int IDX_W    = $clog2(WIN_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cp_we,
    input  logic [ADDR_W-1:0] cp_wdata,
    output logic [ADDR_W-1:0] cp_value,
    input  logic              reg_req,
    input  logic              reg_we,
    input  logic [REG_W-1:0]  reg_num,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              reg_done,
    output logic              reg_err,
    input  logic              dir_req,
    input  logic              dir_we,
    input  logic [ADDR_W-1:0] dir_addr,
    input  logic [DATA_W-1:0] dir_wdata,
    output logic [DATA_W-1:0] dir_rdata,
    output logic              dir_done,
    output logic              dir_err
);

    logic [IDX_W-1:0]  reg_idx;
    logic [IDX_W-1:0]  dir_idx;
    logic              reg_oor;
    logic              dir_oor;
    logic              mem_en;
    logic              mem_we;
    logic              sel_dir;
    logic              reg_rvalid;
    logic              dir_rvalid;
    logic [IDX_W-1:0]  mem_idx;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata;

    rbank_ctx_ptr #(.ADDR_W(ADDR_W), .CP_RESET(CP_RESET)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cp_we),
        .load_val (cp_wdata),
        .ptr      (cp_value)
    );

    rbank_addr_calc #(
        .ADDR_W(ADDR_W), .OFFS_W(REG_W), .WIN_BASE(WIN_BASE), .WIN_WORDS(WIN_WORDS)
    ) u_reg_addr (
        .base       (cp_value),
        .word_offs  (reg_num),
        .word_idx   (reg_idx),
        .out_of_win (reg_oor)
    );

    rbank_addr_calc #(
        .ADDR_W(ADDR_W), .OFFS_W(1), .WIN_BASE(WIN_BASE), .WIN_WORDS(WIN_WORDS)
    ) u_dir_addr (
        .base       (dir_addr),
        .word_offs  (1'b0),
        .word_idx   (dir_idx),
        .out_of_win (dir_oor)
    );

    rbank_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_req    (reg_req),
        .reg_we     (reg_we),
        .reg_oor    (reg_oor),
        .dir_req    (dir_req),
        .dir_we     (dir_we),
        .dir_oor    (dir_oor),
        .mem_en     (mem_en),
        .mem_we     (mem_we),
        .sel_dir    (sel_dir),
        .reg_done   (reg_done),
        .reg_err    (reg_err),
        .reg_rvalid (reg_rvalid),
        .dir_done   (dir_done),
        .dir_err    (dir_err),
        .dir_rvalid (dir_rvalid)
    );

    assign mem_idx   = sel_dir ? dir_idx : reg_idx;
    assign mem_wdata = sel_dir ? dir_wdata : reg_wdata;

    rbank_sram #(.DATA_W(DATA_W), .WORDS(WIN_WORDS)) u_ram (
        .clk   (clk),
        .en    (mem_en),
        .we    (mem_we),
        .idx   (mem_idx),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );

    assign reg_rdata = reg_rvalid ? mem_rdata : '0;
    assign dir_rdata = dir_rvalid ? mem_rdata : '0;

    // R6: an out-of-window register address never reaches the RAM as a write
    a_r6_no_fault_write: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !sel_dir) |-> !reg_oor);

    // R6: the error flag only appears together with completion
    a_r6_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        reg_err |-> reg_done);

    // R10: direct grants only for in-window addresses
    a_r10_dir_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && sel_dir) |-> !dir_oor);

    // R4: the pointer holds without a load
    a_r4_cp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cp_we |=> $stable(cp_value));

endmodule

// File: tb/test_reg_bank_ctx.sv
`timescale 1ns/1ps
module test_reg_bank_ctx;

    localparam int BASE  = 256;
    localparam int WORDS = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cp_we = 1'b0;
    logic [11:0] cp_wdata = '0;
    logic [11:0] cp_value;
    logic        reg_req = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_num = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        reg_done;
    logic        reg_err;
    logic        dir_req = 1'b0;
    logic        dir_we = 1'b0;
    logic [11:0] dir_addr = '0;
    logic [15:0] dir_wdata = '0;
    logic [15:0] dir_rdata;
    logic        dir_done;
    logic        dir_err;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;
    logic [15:0] exp_mem [WORDS];
    int cps [7] = '{256, 289, 304, 480, 496, 248, 224};

    always #2 clk = ~clk;

    reg_bank_ctx i_reg_bank_ctx (
        .clk(clk), .rst_n(rst_n), .cp_we(cp_we), .cp_wdata(cp_wdata), .cp_value(cp_value),
        .reg_req(reg_req), .reg_we(reg_we), .reg_num(reg_num), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .reg_done(reg_done), .reg_err(reg_err),
        .dir_req(dir_req), .dir_we(dir_we), .dir_addr(dir_addr), .dir_wdata(dir_wdata),
        .dir_rdata(dir_rdata), .dir_done(dir_done), .dir_err(dir_err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic bit in_win(input int a);
        return (a >= BASE) && (a < BASE + 2 * WORDS);
    endfunction

    task automatic reg_access(input bit we, input int num, input logic [15:0] wd,
                              output logic [15:0] rd, output logic er);
        @(negedge clk);
        reg_req = 1'b1; reg_we = we; reg_num = 4'(num); reg_wdata = wd;
        @(negedge clk);
        chk(reg_done === 1'b1, "R8 reg done one cycle after request", int'(reg_done), 1);
        rd = reg_rdata; er = reg_err;
        reg_req = 1'b0;
    endtask

    task automatic dir_access(input bit we, input int addr, input logic [15:0] wd,
                              output logic [15:0] rd, output logic er);
        @(negedge clk);
        dir_req = 1'b1; dir_we = we; dir_addr = 12'(addr); dir_wdata = wd;
        @(negedge clk);
        chk(dir_done === 1'b1, "R8 dir done one cycle after request", int'(dir_done), 1);
        rd = dir_rdata; er = dir_err;
        dir_req = 1'b0;
    endtask

    task automatic cp_write(input int v);
        @(negedge clk);
        cp_we = 1'b1; cp_wdata = 12'(v);
        @(negedge clk);
        cp_we = 1'b0;
    endtask

    task automatic sweep_ram(input string tag);
        logic [15:0] rd;
        logic er;
        for (int i = 0; i < WORDS; i++) begin
            dir_access(1'b0, BASE + 2 * i, 16'h0, rd, er);
            chk(rd === exp_mem[i] && er === 1'b0, tag, int'(rd), int'(exp_mem[i]));
        end
    endtask

    task automatic report;
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        logic [15:0] rd;
        logic er;
        int a;
        int cpe;
        logic [15:0] v;

        repeat (2) @(negedge clk);
        // R1: state while in reset
        chk(cp_value === 12'h100, "R1 cp during reset", int'(cp_value), 256);
        chk(reg_done === 1'b0 && dir_done === 1'b0, "R1 done low in reset", int'(reg_done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cp_value === 12'h100, "R1 cp after reset", int'(cp_value), 256);
        chk(reg_err === 1'b0 && dir_err === 1'b0, "R1 err low after reset", int'(reg_err), 0);

        // R7: fill the window through the direct port
        for (int i = 0; i < WORDS; i++) begin
            exp_mem[i] = 16'((i * 16'h0101) ^ 16'h5A5A);
            dir_access(1'b1, BASE + 2 * i, exp_mem[i], rd, er);
            chk(er === 1'b0, "R7 direct fill no error", int'(er), 0);
        end
        sweep_ram("R7 direct readback after fill");

        // R2 R3 R6 R7: pointer sweep across all register numbers
        foreach (cps[k]) begin
            cp_write(cps[k]);
            cpe = cps[k] & ~1;
            chk(cp_value === 12'(cpe), "R3 cp bit0 forced low", int'(cp_value), cpe);
            for (int r = 0; r < 16; r++) begin
                a = cpe + 2 * r;
                reg_access(1'b0, r, 16'h0, rd, er);
                if (in_win(a)) begin
                    chk(rd === exp_mem[(a - BASE) / 2] && er === 1'b0, "R2 register read address",
                        int'(rd), int'(exp_mem[(a - BASE) / 2]));
                end else begin
                    chk(rd === 16'h0 && er === 1'b1, "R6 register read out of window", int'(rd), 0);
                end
                v = 16'((cpe * 31 + r * 977) ^ 16'h3C3C);
                reg_access(1'b1, r, v, rd, er);
                if (in_win(a)) begin
                    exp_mem[(a - BASE) / 2] = v;
                    chk(er === 1'b0, "R2 register write no error", int'(er), 0);
                end else begin
                    chk(er === 1'b1, "R6 register write out of window", int'(er), 1);
                end
            end
            sweep_ram("R6 R7 RAM image after register sweep");
        end

        // R5: overlapping banks alias
        cp_write(12'h120);
        reg_access(1'b1, 10, 16'hBEEF, rd, er);
        exp_mem[(12'h120 + 20 - BASE) / 2] = 16'hBEEF;
        cp_write(12'h130);
        reg_access(1'b0, 2, 16'h0, rd, er);
        chk(rd === 16'hBEEF, "R5 aliased register in overlapping bank", int'(rd), 16'hBEEF);

        // R4: switching banks copies nothing
        cp_write(12'h140);
        reg_access(1'b1, 0, 16'h1111, rd, er);
        exp_mem[(12'h140 - BASE) / 2] = 16'h1111;
        cp_write(12'h160);
        reg_access(1'b0, 0, 16'h0, rd, er);
        chk(rd === exp_mem[(12'h160 - BASE) / 2], "R4 new bank keeps its own data",
            int'(rd), int'(exp_mem[(12'h160 - BASE) / 2]));
        cp_write(12'h140);
        reg_access(1'b0, 0, 16'h0, rd, er);
        chk(rd === 16'h1111, "R4 old bank intact after switch", int'(rd), 16'h1111);

        // R4: pointer write in the access cycle uses the old pointer
        @(negedge clk);
        cp_we = 1'b1; cp_wdata = 12'h180;
        reg_req = 1'b1; reg_we = 1'b1; reg_num = 4'd1; reg_wdata = 16'h7777;
        @(negedge clk);
        cp_we = 1'b0; reg_req = 1'b0;
        chk(cp_value === 12'h180, "R4 pointer loaded", int'(cp_value), 12'h180);
        exp_mem[(12'h142 - BASE) / 2] = 16'h7777;
        sweep_ram("R4 same-cycle write used old pointer");

        // R10: direct port outside the window
        dir_access(1'b1, 12'h0FE, 16'hDEAD, rd, er);
        chk(er === 1'b1, "R10 direct write below window", int'(er), 1);
        dir_access(1'b0, 12'h200, 16'h0, rd, er);
        chk(er === 1'b1 && rd === 16'h0, "R10 direct read above window", int'(rd), 0);
        dir_access(1'b1, 12'h200, 16'hDEAD, rd, er);
        chk(er === 1'b1, "R10 direct write above window", int'(er), 1);
        dir_access(1'b1, 12'h105, 16'h4242, rd, er);
        exp_mem[2] = 16'h4242;
        dir_access(1'b0, 12'h104, 16'h0, rd, er);
        chk(rd === 16'h4242, "R10 direct bit0 ignored", int'(rd), 16'h4242);
        sweep_ram("R10 no trace of faulting direct writes");

        // R9: simultaneous requests
        cp_write(12'h100);
        @(negedge clk);
        reg_req = 1'b1; reg_we = 1'b0; reg_num = 4'd3;
        dir_req = 1'b1; dir_we = 1'b0; dir_addr = 12'h110;
        @(negedge clk);
        chk(reg_done === 1'b1 && dir_done === 1'b0, "R9 register served first", int'(dir_done), 0);
        chk(reg_rdata === exp_mem[3], "R9 register data", int'(reg_rdata), int'(exp_mem[3]));
        reg_req = 1'b0;
        @(negedge clk);
        chk(dir_done === 1'b0 && reg_done === 1'b0, "R8 gap cycle after register ack", int'(dir_done), 0);
        @(negedge clk);
        chk(dir_done === 1'b1 && dir_rdata === exp_mem[8], "R9 direct served after", int'(dir_rdata),
            int'(exp_mem[8]));
        dir_req = 1'b0;
        @(negedge clk);
        chk(dir_done === 1'b0 && dir_rdata === 16'h0, "R8 read data zero when idle", int'(dir_rdata), 0);

        report();
    end

endmodule